// File: doc/BRIEF.md
# Stopped-Clock Watchdog

This block decides whether a monitored system clock has stopped. It uses an independent reference clock that always runs. Each rising edge of the monitored clock flips a one-bit flag in the monitored domain. That flag crosses into the reference domain through a chain of synchronizer flops, and a change of the synchronized value counts as proof that the monitored clock is alive.

A reference-domain counter measures the time since the last such proof. If the count reaches the timeout before a new edge arrives, the block emits a one-cycle request. That request is meant for the reset-cause logic, where it marks a lost clock. It does not drive the chip's external reset pin. After each request the counter reloads, so a clock that stays stopped produces a new request once every timeout period.

The timeout comes from two parameters, the reference frequency in hertz and the window length in nanoseconds. The default window is 100 microseconds. Detection runs only while the enable input is high.

Top module: `clk_loss_monitor`

## Requirements
- R1: While `arst_n` is low, `clk_lost_req` is 0. The edge flag, the synchronizer and the counter are all cleared.
- R2: The timeout length, LIMIT, equals ceil(REF_HZ * WINDOW_NS / 1e9) reference cycles. While the monitored clock stays stopped and detection is enabled, successive requests are exactly LIMIT reference cycles apart.
- R3: Each rising edge of `mon_clk` restarts the count. A series of rising edges whose spacing never exceeds LIMIT reference cycles produces no request.
- R4: After the last rising edge of `mon_clk`, the first request appears between LIMIT and LIMIT+4 reference cycles later. This allows for the synchronizer delay, so the request never comes before the full window has passed.
- R5: `clk_lost_req` is high for exactly one reference cycle per timeout.
- R6: While `det_en` is 0, no request is made and the counter stays at zero. If `det_en` drops, no request follows in the next cycle.
- R7: When `det_en` rises with the monitored clock already stopped, the first request comes no earlier than LIMIT-1 cycles later. Enabling never causes an immediate request.
- R8: If a synchronized rising edge arrives in the same cycle in which the counter reaches its last value, the edge wins. No request is made and the count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mon_clk | input | 1 | Monitored system clock; only its rising edges are used |
| ref_clk | input | 1 | Free-running reference clock that times the window |
| arst_n | input | 1 | Asynchronous active-low reset for both domains |
| det_en | input | 1 | Detection enable, synchronous to `ref_clk`; 1 runs, 0 holds idle |
| clk_lost_req | output | 1 | One-cycle reference-domain pulse on timeout |

## Verification
Two events can land in the same reference cycle: the re-arm from a synchronized monitored edge and the terminal count that fires a request. The bench provokes this by sweeping the gap between two monitored edges across a few cycles either side of LIMIT, so that one gap lines the edge up with the terminal cycle. For every gap in the sweep, the bench requires at most one request. After the sweep, a short gap must leave the output silent, which shows that the count really restarted from zero. A bound checker asserts that an edge seen while enabled always suppresses the request in the following cycle.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;

  // Reference cycles in the window, rounded up: ceil(hz * ns / 1e9).
  function automatic longint unsigned cycles_for(longint unsigned hz,
                                                 longint unsigned ns);
    longint unsigned prod;
    prod = hz * ns;
    return (prod + 64'd999_999_999) / 64'd1_000_000_000;
  endfunction

  // Counter width that can hold the value n.
  function automatic int width_for(longint unsigned n);
    int w;
    w = 1;
    while ((64'd1 << w) <= n) w++;
    return w;
  endfunction

endpackage

// File: rtl/clkmon_toggle.sv
module clkmon_toggle (
  input  logic mon_clk,
  input  logic arst_n,
  output logic flag_o
);
  // The flag flips on every rising edge of the monitored clock.
  always_ff @(posedge mon_clk or negedge arst_n) begin
    if (!arst_n) flag_o <= 1'b0;
    else         flag_o <= ~flag_o;
  end
endmodule

// File: rtl/clkmon_edge_sync.sv
module clkmon_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic async_i,
  output logic change_o
);
  localparam int TAPS = STAGES + 1;

  // sh[0..STAGES-1] form the synchronizer; sh[STAGES] holds the last value.
  logic [TAPS-1:0] sh;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh <= '0;
    else         sh <= {sh[TAPS-2:0], async_i};
  end

  assign change_o = sh[STAGES] ^ sh[STAGES-1];
endmodule

// File: rtl/clkmon_timer.sv
module clkmon_timer #(
  parameter int LIMIT = 20000,
  parameter int CW    = 15
) (
  input  logic          clk,
  input  logic          arst_n,
  input  logic          en,
  input  logic          rearm,
  output logic [CW-1:0] cnt_o,
  output logic          req_o
);
  localparam logic [CW-1:0] TERM = CW'(LIMIT - 1);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_o <= '0;
      req_o <= 1'b0;
    end else begin
      req_o <= 1'b0;
      if (!en) begin
        cnt_o <= '0;
      end else if (rearm) begin
        cnt_o <= '0;
      end else if (cnt_o == TERM) begin
        cnt_o <= '0;
        req_o <= 1'b1;
      end else begin
        cnt_o <= cnt_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/clk_loss_monitor.sv
module clk_loss_monitor #(
  parameter longint unsigned REF_HZ      = 200_000_000,
  parameter longint unsigned WINDOW_NS   = 100_000,
  parameter int              SYNC_STAGES = 2
) (
  input  logic mon_clk,
  input  logic ref_clk,
  input  logic arst_n,
  input  logic det_en,
  output logic clk_lost_req
);
  localparam int LIMIT = int'(clkmon_pkg::cycles_for(REF_HZ, WINDOW_NS));
  localparam int CW    = clkmon_pkg::width_for(longint'(LIMIT));

  // Named events, brought out for the checker.
  logic          mon_flag;
  logic          edge_seen;
  logic [CW-1:0] cnt;
  logic [31:0]   cnt_w;
  logic [31:0]   term_w;

  clkmon_toggle u_tog (
    .mon_clk (mon_clk),
    .arst_n  (arst_n),
    .flag_o  (mon_flag)
  );

  clkmon_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (ref_clk),
    .arst_n   (arst_n),
    .async_i  (mon_flag),
    .change_o (edge_seen)
  );

  clkmon_timer #(.LIMIT(LIMIT), .CW(CW)) u_tmr (
    .clk    (ref_clk),
    .arst_n (arst_n),
    .en     (det_en),
    .rearm  (edge_seen),
    .cnt_o  (cnt),
    .req_o  (clk_lost_req)
  );

  assign cnt_w  = 32'(cnt);
  assign term_w = 32'(LIMIT - 1);
endmodule

// File: rtl/clk_loss_monitor_chk.sv
module clk_loss_monitor_chk (
  input logic        ref_clk,
  input logic        arst_n,
  input logic        det_en,
  input logic        edge_seen,
  input logic        clk_lost_req,
  input logic [31:0] cnt_w,
  input logic [31:0] term_w
);
  p_one_cycle_r5: assert property (@(posedge ref_clk) disable iff (!arst_n)
    clk_lost_req |=> !clk_lost_req);

  p_quiet_off_r6: assert property (@(posedge ref_clk) disable iff (!arst_n)
    !det_en |=> !clk_lost_req);

  p_cnt_idle_r6: assert property (@(posedge ref_clk) disable iff (!arst_n)
    !det_en |=> (cnt_w == 32'd0));

  p_rearm_r3: assert property (@(posedge ref_clk) disable iff (!arst_n)
    (det_en && edge_seen) |=> (cnt_w == 32'd0));

  p_edge_wins_r8: assert property (@(posedge ref_clk) disable iff (!arst_n)
    (det_en && edge_seen) |=> !clk_lost_req);

  p_reload_r2: assert property (@(posedge ref_clk) disable iff (!arst_n)
    clk_lost_req |-> (cnt_w == 32'd0));

  p_bound_r2: assert property (@(posedge ref_clk) disable iff (!arst_n)
    cnt_w <= term_w);
endmodule

bind clk_loss_monitor clk_loss_monitor_chk u_chk (
  .ref_clk      (ref_clk),
  .arst_n       (arst_n),
  .det_en       (det_en),
  .edge_seen    (edge_seen),
  .clk_lost_req (clk_lost_req),
  .cnt_w        (cnt_w),
  .term_w       (term_w)
);

// File: tb/clk_loss_monitor_test.sv
`timescale 1ns/1ps
module clk_loss_monitor_test;
  localparam longint unsigned HZ  = 200_000_000;
  localparam longint unsigned WNS = 500;

  // Independent restatement: window in ps divided by period in ps, rounded up.
  function automatic int exp_limit(longint unsigned hz, longint unsigned ns);
    longint unsigned per_ps, win_ps;
    per_ps = 64'd1_000_000_000_000 / hz;
    win_ps = ns * 1000;
    return int'((win_ps + per_ps - 1) / per_ps);
  endfunction

  localparam int L = exp_limit(HZ, WNS);

  logic ref_clk = 0, mon_clk = 0, arst_n = 0, det_en = 0;
  logic clk_lost_req;
  int checks = 0, errors = 0;
  int cyc = 0, win = 0, first_at = -1, last_at = -1;
  bit prev_req = 0, track_int = 0;

  clk_loss_monitor #(.REF_HZ(HZ), .WINDOW_NS(WNS)) uut (
    .mon_clk(mon_clk), .ref_clk(ref_clk), .arst_n(arst_n),
    .det_en(det_en), .clk_lost_req(clk_lost_req));

  always #2.5 ref_clk = ~ref_clk;
  always @(posedge ref_clk) cyc++;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Pulse monitor, sampled on the falling edge.
  always @(negedge ref_clk) begin
    if (arst_n && clk_lost_req) begin
      if (win == 0) first_at = cyc;
      win++;
      if (prev_req) chk(0, "R5 pulse width", 2, 1);
      if (track_int && last_at >= 0) chk((cyc - last_at) == L, "R2 interval", cyc - last_at, L);
      last_at = cyc;
    end
    prev_req = clk_lost_req;
  end

  int edge_at = 0;
  task automatic mon_edge();
    @(posedge ref_clk); #1.2;
    mon_clk = 1; edge_at = cyc; win = 0; first_at = -1; last_at = -1;
    #3 mon_clk = 0;
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge ref_clk);
  endtask

  initial begin
    #900_000;
    chk(0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    // R1 reset state
    wait_cyc(4);
    chk(clk_lost_req == 0, "R1 reset", clk_lost_req, 0);
    chk(L == 100, "R2 limit", L, 100);
    @(negedge ref_clk); arst_n = 1;
    wait_cyc(2);
    chk(clk_lost_req == 0, "R1 after release", clk_lost_req, 0);

    // R3 regular edges keep it quiet
    @(negedge ref_clk); det_en = 1;
    for (int i = 0; i < 40; i++) begin
      mon_edge();
      wait_cyc($urandom_range(2, L - 8));
    end
    mon_edge();
    wait_cyc(L - 8);
    chk(win == 0, "R3 no request with edges", win, 0);

    // R4 first pulse after stop, R2 interval, R5 width
    mon_edge();
    track_int = 1;
    wait_cyc(3 * L + L / 2);
    track_int = 0;
    chk(first_at - edge_at >= L && first_at - edge_at <= L + 4,
        "R4 first delay", first_at - edge_at, L);
    chk(win == 3, "R2 repeat count", win, 3);

    // R6 disabled: silent
    @(negedge ref_clk); det_en = 0; win = 0;
    wait_cyc(3 * L);
    chk(win == 0, "R6 disabled quiet", win, 0);

    // R7 enable with clock stopped
    @(negedge ref_clk); det_en = 1; edge_at = cyc; first_at = -1;
    wait_cyc(L + 6);
    chk(first_at - edge_at >= L - 1 && first_at - edge_at <= L + 1,
        "R7 first after enable", first_at - edge_at, L);

    // R6 drop mid-count cancels
    wait_cyc(L / 2);
    @(negedge ref_clk); det_en = 0; win = 0;
    wait_cyc(5);
    @(negedge ref_clk); det_en = 1; edge_at = cyc; first_at = -1;
    wait_cyc(L - 3);
    chk(win == 0, "R6 restart after re-enable", win, 0);
    wait_cyc(6);
    chk(first_at - edge_at >= L - 1 && first_at - edge_at <= L + 1,
        "R7 re-enable timing", first_at - edge_at, L);

    // Random gaps
    for (int i = 0; i < 30; i++) begin
      int g;
      g = ($urandom_range(0, 1) == 1) ? $urandom_range(20, L) : $urandom_range(L + 5, 2 * L - 6);
      mon_edge();
      wait_cyc(g - 1);
      if (g <= L) chk(win == 0, "R3 random short gap", win, 0);
      else        chk(win == 1, "R4 random long gap", win, 1);
    end

    // R8 sweep edge position across terminal count
    for (int g = L - 3; g <= L + 5; g++) begin
      mon_edge();
      wait_cyc(g - 1);
      chk(win <= 1, "R8 sweep at most one", win, 1);
    end
    mon_edge();
    wait_cyc(L - 8);
    chk(win == 0, "R8 reload after sweep", win, 0);
    mon_edge();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule